// File: doc/BRIEF.md
# Segmented Invert-on-Write Block Codec

This block sits in front of a non-volatile memory array and cuts the number of cells programmed per block write. The stored block is split into a payload area and a small flag field. The payload is cut into equal segments. For each segment the encoder counts how many bits would change if the new data replaced the bits now held in the array. When more than half of the segment would change, it stores the complement of that segment and sets the segment's flag. The flags use the top bits of the block, which compression has freed, so the array needs no extra columns.

A decoder path takes a physical block as read from the array. It complements every flagged segment and returns the logical payload. Both paths are pipelined and accept one block per cycle. Encoding takes four cycles and decoding takes two.

Top module: `flip_write_codec`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `enc_out_valid` and `dec_out_valid` are low. A request presented during reset never produces a result.
- R2: Block layout: the payload is bits [PAY_W-1:0], with PAY_W = BLK_W - NSEG. Segment s is payload bits [s*SEG_W +: SEG_W], with SEG_W = PAY_W / NSEG. The flag for segment s is block bit PAY_W + s, so the flags fill the top NSEG bits of the block.
- R3: For each segment, the encoder counts the bits that differ between the new logical segment and the old physical payload bits, inverted or not. If that count exceeds SEG_W/2, the segment is stored complemented and its flag is 1.
- R4: If the count is at most SEG_W/2, the segment is stored unchanged and its flag is 0. This includes a count of exactly half when SEG_W is even.
- R5: `enc_out_valid` rises exactly 4 clock cycles after `enc_valid` is sampled high, and `enc_blk` carries that request's result. Back-to-back requests give back-to-back results. `enc_out_valid` is low in every other cycle.
- R6: `dec_out_valid` rises exactly 2 cycles after `dec_valid` is sampled high and is low otherwise.
- R7: The decoder outputs the payload of `dec_blk` with every segment whose flag is 1 complemented.
- R8: Decoding an encoded block returns the original logical payload, for any old contents.
- R9: Within any one segment, the stored payload differs from the old physical payload in at most SEG_W/2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | Encode request strobe |
| enc_new | input | PAY_W | New logical payload |
| enc_old_pay | input | PAY_W | Physical payload bits now in the array |
| enc_out_valid | output | 1 | Encoded block valid |
| enc_blk | output | BLK_W | Block to program: flags on top, payload below |
| dec_valid | input | 1 | Decode request strobe |
| dec_blk | input | BLK_W | Physical block read from the array |
| dec_out_valid | output | 1 | Decoded payload valid |
| dec_data | output | PAY_W | Recovered logical payload |

## Verification
The bench builds the codec with BLK_W = 18 and NSEG = 2. This gives two 8-bit segments, and the even width places the exact-half tie on every path. Against a fixed old payload, a sweep of all 65536 new payloads covers all 256 difference patterns in each segment, including every count from 0 to 8. A random phase with sparse strobes and changing old contents then exercises the pipeline timing. The encoder output feeds the decoder, so every encode is also checked as a round trip.

// File: rtl/flip_codec_pkg.sv
package flip_codec_pkg;
   localparam int unsigned DEF_BLK_W  = 512;
   localparam int unsigned DEF_NSEG   = 8;
   localparam int unsigned ENC_STAGES = 4;
   localparam int unsigned DEC_STAGES = 2;

   // Width needed to hold a count of 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/flip_seg_popcnt.sv
module flip_seg_popcnt #(
   parameter int unsigned W  = 63,
   parameter int unsigned CW = flip_codec_pkg::cnt_width(W)
) (
   input  logic [W-1:0]  bits,
   output logic [CW-1:0] ones
);
   localparam int unsigned LO_W  = W / 2;
   localparam int unsigned HI_W  = W - LO_W;
   localparam int unsigned LO_CW = flip_codec_pkg::cnt_width(LO_W);
   localparam int unsigned HI_CW = flip_codec_pkg::cnt_width(HI_W);

   generate
      if (W == 1) begin : g_leaf
         assign ones = CW'(bits[0]);
      end else begin : g_split
         logic [LO_CW-1:0] lo_ones;
         logic [HI_CW-1:0] hi_ones;
         flip_seg_popcnt #(.W(LO_W), .CW(LO_CW)) u_lo (.bits(bits[LO_W-1:0]), .ones(lo_ones));
         flip_seg_popcnt #(.W(HI_W), .CW(HI_CW)) u_hi (.bits(bits[W-1:LO_W]), .ones(hi_ones));
         assign ones = CW'(lo_ones) + CW'(hi_ones);
      end
   endgenerate
endmodule

// File: rtl/flip_enc_pipe.sv
module flip_enc_pipe #(
   parameter int unsigned PAY_W = 504,
   parameter int unsigned NSEG  = 8,
   parameter int unsigned SEG_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PAY_W-1:0] in_new,
   input  logic [PAY_W-1:0] in_old,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_pay,
   output logic [NSEG-1:0]  out_flag
);
   localparam int unsigned CW   = flip_codec_pkg::cnt_width(SEG_W);
   localparam int unsigned HALF = SEG_W / 2;

   // stage 1: capture and difference
   logic             v1;
   logic [PAY_W-1:0] new1;
   logic [PAY_W-1:0] diff1;
   // stage 2: per-segment change counts
   logic             v2;
   logic [PAY_W-1:0] new2;
   logic [CW-1:0]    cnt_c [NSEG];
   logic [CW-1:0]    cnt2  [NSEG];
   // stage 3: inversion decision
   logic             v3;
   logic [PAY_W-1:0] new3;
   logic [NSEG-1:0]  inv3;
   logic [PAY_W-1:0] inv_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         v3 <= v2;
         out_valid <= v3;
      end
   end

   always_ff @(posedge clk) begin
      new1  <= in_new;
      diff1 <= in_new ^ in_old;
      new2  <= new1;
      new3  <= new2;
   end

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         flip_seg_popcnt #(.W(SEG_W), .CW(CW)) u_cnt (
            .bits (diff1[s*SEG_W +: SEG_W]),
            .ones (cnt_c[s])
         );
         always_ff @(posedge clk) begin
            cnt2[s] <= cnt_c[s];
            inv3[s] <= (cnt2[s] > CW'(HALF));
         end
         assign inv_mask[s*SEG_W +: SEG_W] = {SEG_W{inv3[s]}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      out_pay  <= new3 ^ inv_mask;
      out_flag <= inv3;
   end
endmodule

// File: rtl/flip_dec_pipe.sv
module flip_dec_pipe #(
   parameter int unsigned PAY_W = 504,
   parameter int unsigned NSEG  = 8,
   parameter int unsigned SEG_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PAY_W-1:0] in_pay,
   input  logic [NSEG-1:0]  in_flag,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_data
);
   logic             v1;
   logic [PAY_W-1:0] pay1;
   logic [NSEG-1:0]  flag1;
   logic [PAY_W-1:0] undo_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v1 <= in_valid;
         out_valid <= v1;
      end
   end

   always_ff @(posedge clk) begin
      pay1  <= in_pay;
      flag1 <= in_flag;
   end

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         assign undo_mask[s*SEG_W +: SEG_W] = {SEG_W{flag1[s]}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      out_data <= pay1 ^ undo_mask;
   end
endmodule

// File: rtl/flip_write_codec.sv
module flip_write_codec #(
   parameter int unsigned BLK_W = flip_codec_pkg::DEF_BLK_W,
   parameter int unsigned NSEG  = flip_codec_pkg::DEF_NSEG,
   localparam int unsigned PAY_W = BLK_W - NSEG,
   localparam int unsigned SEG_W = PAY_W / NSEG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_valid,
   input  logic [PAY_W-1:0] enc_new,
   input  logic [PAY_W-1:0] enc_old_pay,
   output logic             enc_out_valid,
   output logic [BLK_W-1:0] enc_blk,
   input  logic             dec_valid,
   input  logic [BLK_W-1:0] dec_blk,
   output logic             dec_out_valid,
   output logic [PAY_W-1:0] dec_data
);
   generate
      if (NSEG < 1 || NSEG >= BLK_W) begin : g_bad_nseg
         $error("flip_write_codec: NSEG must be in 1..BLK_W-1");
      end
      if (PAY_W % NSEG != 0) begin : g_bad_split
         $error("flip_write_codec: payload width must divide evenly into NSEG segments");
      end
      if (SEG_W < 2) begin : g_bad_segw
         $error("flip_write_codec: segments must be at least 2 bits wide");
      end
   endgenerate

   logic [PAY_W-1:0] enc_pay;
   logic [NSEG-1:0]  enc_flag;

   flip_enc_pipe #(.PAY_W(PAY_W), .NSEG(NSEG), .SEG_W(SEG_W)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (enc_valid),
      .in_new    (enc_new),
      .in_old    (enc_old_pay),
      .out_valid (enc_out_valid),
      .out_pay   (enc_pay),
      .out_flag  (enc_flag)
   );

   assign enc_blk = {enc_flag, enc_pay};

   flip_dec_pipe #(.PAY_W(PAY_W), .NSEG(NSEG), .SEG_W(SEG_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dec_valid),
      .in_pay    (dec_blk[PAY_W-1:0]),
      .in_flag   (dec_blk[BLK_W-1:PAY_W]),
      .out_valid (dec_out_valid),
      .out_data  (dec_data)
   );
endmodule

// File: rtl/flip_write_codec_chk.sv
module flip_write_codec_chk #(
   parameter int unsigned BLK_W = flip_codec_pkg::DEF_BLK_W,
   parameter int unsigned NSEG  = flip_codec_pkg::DEF_NSEG,
   localparam int unsigned PAY_W = BLK_W - NSEG,
   localparam int unsigned SEG_W = PAY_W / NSEG
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enc_valid,
   input logic [PAY_W-1:0] enc_new,
   input logic [PAY_W-1:0] enc_old_pay,
   input logic             enc_out_valid,
   input logic [BLK_W-1:0] enc_blk,
   input logic             dec_valid,
   input logic [BLK_W-1:0] dec_blk,
   input logic             dec_out_valid,
   input logic [PAY_W-1:0] dec_data
);
   localparam int unsigned HALF = SEG_W / 2;

   logic [2:0]       warm;
   logic [PAY_W-1:0] old_q [4];
   logic [BLK_W-1:0] dblk_q [2];
   int unsigned      prog_cnt [NSEG];

   always_ff @(posedge clk) begin
      if (!rst_n) warm <= '0;
      else if (warm != 3'd7) warm <= warm + 3'd1;
   end

   always_ff @(posedge clk) begin
      old_q[0]  <= enc_old_pay;
      old_q[1]  <= old_q[0];
      old_q[2]  <= old_q[1];
      old_q[3]  <= old_q[2];
      dblk_q[0] <= dec_blk;
      dblk_q[1] <= dblk_q[0];
   end

   always_comb begin
      for (int s = 0; s < NSEG; s++) begin
         prog_cnt[s] = 0;
         for (int b = 0; b < SEG_W; b++)
            prog_cnt[s] += int'(enc_blk[s*SEG_W+b] ^ old_q[3][s*SEG_W+b]);
      end
   end

   // R1: no result straight out of reset
   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!enc_out_valid && !dec_out_valid));

   // R5: encode result four cycles after request, and only then
   a_r5_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> ##4 enc_out_valid);
   a_r5_enc_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_out_valid && warm >= 3'd4) |-> $past(enc_valid, 4));

   // R6: decode result two cycles after request
   a_r6_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ##2 dec_out_valid);

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         // R9: programming bound per segment
         a_r9_prog_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (enc_out_valid && warm >= 3'd4) |-> (prog_cnt[s] <= HALF));
         // R7: flagged segments come back complemented
         a_r7_unflip: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_out_valid && warm >= 3'd2) |->
               (dec_data[s*SEG_W +: SEG_W] ==
                (dblk_q[1][s*SEG_W +: SEG_W] ^ {SEG_W{dblk_q[1][PAY_W+s]}})));
      end
   endgenerate
endmodule

bind flip_write_codec flip_write_codec_chk #(.BLK_W(BLK_W), .NSEG(NSEG)) u_chk (.*);

// File: tb/flip_write_codec_bench.sv
module flip_write_codec_bench;
   localparam int unsigned BLK_W = 18;
   localparam int unsigned NSEG  = 2;
   localparam int unsigned PAY_W = BLK_W - NSEG;
   localparam int unsigned SEG_W = PAY_W / NSEG;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enc_valid = 1'b0;
   logic [PAY_W-1:0] enc_new = '0;
   logic [PAY_W-1:0] enc_old_pay = '0;
   logic             enc_out_valid;
   logic [BLK_W-1:0] enc_blk;
   logic             dec_valid;
   logic [BLK_W-1:0] dec_blk;
   logic             dec_out_valid;
   logic [PAY_W-1:0] dec_data;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic             h_v   [6];
   logic [PAY_W-1:0] h_new [6];
   logic [PAY_W-1:0] h_old [6];

   always #4 clk = ~clk;

   // encoder output is fed straight back into the decoder (round trip)
   assign dec_valid = enc_out_valid;
   assign dec_blk   = enc_blk;

   flip_write_codec #(.BLK_W(BLK_W), .NSEG(NSEG)) u_flip_write_codec (
      .clk(clk), .rst_n(rst_n),
      .enc_valid(enc_valid), .enc_new(enc_new), .enc_old_pay(enc_old_pay),
      .enc_out_valid(enc_out_valid), .enc_blk(enc_blk),
      .dec_valid(dec_valid), .dec_blk(dec_blk),
      .dec_out_valid(dec_out_valid), .dec_data(dec_data)
   );

   // R2/R3/R4 reference: flags on top, segments packed from bit 0
   function automatic logic [BLK_W-1:0] model(input logic [PAY_W-1:0] n, input logic [PAY_W-1:0] o);
      logic [BLK_W-1:0] r;
      r = '0;
      for (int s = 0; s < NSEG; s++) begin
         int c;
         c = 0;
         for (int b = 0; b < SEG_W; b++) c += int'(n[s*SEG_W+b] ^ o[s*SEG_W+b]);
         for (int b = 0; b < SEG_W; b++) r[s*SEG_W+b] = (c > SEG_W/2) ? ~n[s*SEG_W+b] : n[s*SEG_W+b];
         r[PAY_W+s] = (c > SEG_W/2);
      end
      return r;
   endfunction

   function automatic int max_prog(input logic [BLK_W-1:0] blk, input logic [PAY_W-1:0] o);
      int m;
      m = 0;
      for (int s = 0; s < NSEG; s++) begin
         int c;
         c = 0;
         for (int b = 0; b < SEG_W; b++) c += int'(blk[s*SEG_W+b] ^ o[s*SEG_W+b]);
         if (c > m) m = c;
      end
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic step(input logic v, input logic [PAY_W-1:0] n, input logic [PAY_W-1:0] o);
      @(negedge clk);
      if (h_v[3]) begin
         logic [BLK_W-1:0] e;
         e = model(h_new[3], h_old[3]);
         chk(enc_out_valid === 1'b1, "R5", BLK_W'(enc_out_valid), BLK_W'(1));
         // R3 when any segment inverts, R4 otherwise (ties stay unflipped)
         chk(enc_blk === e, (e[BLK_W-1:PAY_W] != '0) ? "R3" : "R4", enc_blk, e);
         chk(max_prog(enc_blk, h_old[3]) <= SEG_W/2, "R9",
             BLK_W'(max_prog(enc_blk, h_old[3])), BLK_W'(SEG_W/2));
      end else begin
         chk(enc_out_valid === 1'b0, "R5", BLK_W'(enc_out_valid), '0);
      end
      if (h_v[5]) begin
         chk(dec_out_valid === 1'b1, "R6", BLK_W'(dec_out_valid), BLK_W'(1));
         chk(dec_data === h_new[5], "R7 R8", BLK_W'(dec_data), BLK_W'(h_new[5]));
      end else begin
         chk(dec_out_valid === 1'b0, "R6", BLK_W'(dec_out_valid), '0);
      end
      for (int i = 5; i > 0; i--) begin
         h_v[i] = h_v[i-1]; h_new[i] = h_new[i-1]; h_old[i] = h_old[i-1];
      end
      h_v[0] = v; h_new[0] = n; h_old[0] = o;
      enc_valid = v; enc_new = n; enc_old_pay = o;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 6; i++) begin h_v[i] = 1'b0; h_new[i] = '0; h_old[i] = '0; end
      // R1: requests during reset must not emerge
      enc_valid = 1'b1; enc_new = 16'h1234; enc_old_pay = 16'hFFFF;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!enc_out_valid && !dec_out_valid, "R1", BLK_W'({enc_out_valid, dec_out_valid}), '0);
      end
      rst_n = 1'b1; enc_valid = 1'b0;
      for (int i = 0; i < 6; i++) step(1'b0, '0, '0);

      // R4 tie: exactly half the bits of segment 0 differ -> stored as-is
      step(1'b1, 16'h000F, 16'h0000);
      // R3: five of eight differ in segment 1 -> inverted
      step(1'b1, 16'h1F00, 16'h0000);
      // R3 both segments, old contents all ones
      step(1'b1, 16'h0000, 16'hFFFF);

      // exhaustive sweep of new payloads against a fixed old payload
      for (int k = 0; k < 65536; k++) step(1'b1, PAY_W'(k), 16'hA5C3);

      // sparse random requests with changing old contents
      for (int k = 0; k < 3000; k++)
         step(($urandom_range(0, 9) < 7), PAY_W'($urandom), PAY_W'($urandom));

      for (int i = 0; i < 8; i++) step(1'b0, '0, '0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule